// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with 40-bit Accumulator

This block multiplies two 16-bit operands and combines the product with a 40-bit accumulator that keeps 8 guard bits above a 32-bit word. The operands can be read as signed fractions, unsigned fractions, signed integers, unsigned integers, or as a mixed pair in which the first operand is signed and the second unsigned. When both operands are signed fractions, the product is shifted left by one place so that the result stays in fractional alignment. In all other formats the product is used as is.

On each enabled cycle an operation code selects one of four actions: load the product into the accumulator, add the product to it, subtract the product from it, or clear it. The accumulator saturates at its 40-bit signed limits and raises an overflow flag when this happens. A separate extract select turns the accumulator into a 16-bit half-word, using either rounding or truncation, or into a 32-bit word. The word can be taken directly or doubled. Every extraction saturates to the signed range of its destination. The unit is meant to sit beside a register file that supplies operands and stores results.

Top module: `frac_mac40`

## Requirements
- R1: While rst_n is low at a rising edge, the accumulator and the overflow flag become 0.
- R2: With fmt=0 (signed fraction), the product is the signed product shifted left by one. The one case -1.0 x -1.0 (0x8000 x 0x8000) gives 0x7FFFFFFF.
- R3: With fmt=1 (unsigned fraction), fmt=2 (signed integer) and fmt=3 (unsigned integer), the product is the plain product with no shift, using the stated signedness. With fmt=4 (mixed), a is signed, b is unsigned, and there is no shift.
- R4: When en=1 at a rising edge, op=0 loads the sign-extended product into the accumulator, op=1 adds it and op=2 subtracts it. The new value appears on acc_o right after that edge.
- R5: When en=0 at a rising edge, acc_o and ovf_o keep their values, whatever op holds.
- R6: When en=1 and op=3, the accumulator clears to 0 and ovf_o clears to 0.
- R7: If an add or subtract overflows 40 bits, the accumulator takes 0x7FFFFFFFFF or 0x8000000000 and ovf_o is 1. Every enabled operation rewrites ovf_o; load and clear give 0.
- R8: ext_sel=0 (rounded half) gives bits [31:16] of accumulator+0x8000, saturated to 0x7FFF or 0x8000. The result is sign-extended onto res_o.
- R9: ext_sel=1 (truncated half) gives bits [31:16] of the accumulator, saturated to the 16-bit signed range and sign-extended onto res_o.
- R10: ext_sel=2 gives the accumulator saturated to the 32-bit signed range.
- R11: ext_sel=3 gives twice the accumulator saturated to the 32-bit signed range. res_o follows ext_sel and acc_o with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Perform op on this edge |
| op | input | 2 | 0 load, 1 add, 2 subtract, 3 clear |
| fmt | input | 3 | 0 SF, 1 UF, 2 SI, 3 UI, 4 mixed |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| ext_sel | input | 2 | 0 round half, 1 truncate half, 2 word, 3 doubled word |
| acc_o | output | 40 | Accumulator |
| res_o | output | 32 | Extracted result |
| ovf_o | output | 1 | Overflow of the last enabled operation |

## Verification
acc_o and ovf_o are due one rising edge after the operands and op are presented with en high. The bench drives inputs on the falling edge and checks both outputs at the next falling edge, after exactly one register. res_o is combinational from acc_o and ext_sel. For each extraction check, the bench therefore sets ext_sel away from any edge, waits a fraction of the period, and compares without spending a clock. Overflow windows of 128 and 129 accumulations are counted by the bench loop, not inferred.

// File: rtl/frac_mac_pkg.sv
// Shared encodings for the fractional MAC unit.
package frac_mac_pkg;
    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_CLR = 2'd3} mac_op_e;
    typedef enum logic [2:0] {FMT_SF = 3'd0, FMT_UF = 3'd1, FMT_SI = 3'd2, FMT_UI = 3'd3, FMT_MIX = 3'd4} mac_fmt_e;
    typedef enum logic [1:0] {EXT_HRND = 2'd0, EXT_HTRN = 2'd1, EXT_WORD = 2'd2, EXT_WX2 = 2'd3} mac_ext_e;
endpackage

// File: rtl/mac_mult.sv
// Operand multiplier: extends operands by format, multiplies, applies the
// fractional left shift and the -1 x -1 clamp, sign-extends to ACC_W.
// Assumes ACC_W exceeds 2*OP_W+2.
module mac_mult
    import frac_mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]  a,
    input  logic [OP_W-1:0]  b,
    input  mac_fmt_e         fmt,
    output logic [ACC_W-1:0] prod_o
);
    localparam int PW = 2*OP_W + 2;
    localparam logic [OP_W-1:0] NEG_ONE = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [PW-1:0]   FR_MAX  = {{(PW-2*OP_W+1){1'b0}}, {(2*OP_W-1){1'b1}}};

    logic a_sgn, b_sgn, corner;
    logic signed [OP_W:0] ax, bx;
    logic signed [PW-1:0] raw;
    logic [PW-1:0]        shaped;

    // Operand signedness per format
    always_comb begin
        a_sgn = (fmt == FMT_SF) || (fmt == FMT_SI) || (fmt == FMT_MIX);
        b_sgn = (fmt == FMT_SF) || (fmt == FMT_SI);
        ax = {a_sgn & a[OP_W-1], a};
        bx = {b_sgn & b[OP_W-1], b};
        raw = PW'(ax) * PW'(bx);
    end

    // Fraction alignment and corner clamp
    always_comb begin
        corner = (fmt == FMT_SF) && (a == NEG_ONE) && (b == NEG_ONE);
        if (corner)
            shaped = FR_MAX;
        else if (fmt == FMT_SF)
            shaped = {raw[PW-2:0], 1'b0};
        else
            shaped = raw;
        prod_o = {{(ACC_W-PW){shaped[PW-1]}}, shaped};
    end

    // R3: unsigned-by-unsigned products are never negative
    always_comb begin
        if (fmt == FMT_UF || fmt == FMT_UI)
            a_r3_unsigned_nonneg: assert (prod_o[ACC_W-1] == 1'b0);
    end
endmodule

// File: rtl/mac_accum.sv
// Accumulator register with load/add/subtract/clear and 40-bit saturation.
// Overflow flag reflects the last enabled operation.
module mac_accum
    import frac_mac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  mac_op_e          op,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] acc_q,
    output logic             ovf_q
);
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0]   sum;
    logic             sum_ovf;
    logic [ACC_W-1:0] sum_sat;

    // Wide add/subtract with overflow detection and clamp
    always_comb begin
        if (op == OP_SUB)
            sum = {acc_q[ACC_W-1], acc_q} - {prod[ACC_W-1], prod};
        else
            sum = {acc_q[ACC_W-1], acc_q} + {prod[ACC_W-1], prod};
        sum_ovf = sum[ACC_W] ^ sum[ACC_W-1];
        sum_sat = sum_ovf ? (sum[ACC_W] ? ACC_MIN : ACC_MAX) : sum[ACC_W-1:0];
    end

    // Accumulator and flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (en) begin
            case (op)
                OP_LOAD: begin acc_q <= prod;    ovf_q <= 1'b0;    end
                OP_ADD,
                OP_SUB:  begin acc_q <= sum_sat; ovf_q <= sum_ovf; end
                default: begin acc_q <= '0;      ovf_q <= 1'b0;    end
            endcase
        end
    end

    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        en && op == OP_LOAD |=> acc_q == $past(prod) && !ovf_q);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q) && $stable(ovf_q));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        en && op == OP_CLR |=> acc_q == '0 && !ovf_q);
    a_r7_sat_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> acc_q == ACC_MAX || acc_q == ACC_MIN);
endmodule

// File: rtl/mac_extract.sv
// Combinational extraction of half-word (round/truncate) or word (plain or
// doubled) from the accumulator, each saturated to signed range.
module mac_extract
    import frac_mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0]  acc,
    input  mac_ext_e          sel,
    output logic [2*OP_W-1:0] res_o
);
    localparam int XW = ACC_W + 1;
    localparam int WW = 2 * OP_W;
    localparam logic [XW-1:0] RND_INC = XW'(1) << (OP_W - 1);

    function automatic logic [WW-1:0] sat_word(input logic [XW-1:0] v);
        logic fits;
        fits = (&v[XW-1:WW-1]) | ~(|v[XW-1:WW-1]);
        if (fits)
            return v[WW-1:0];
        return v[XW-1] ? {1'b1, {(WW-1){1'b0}}} : {1'b0, {(WW-1){1'b1}}};
    endfunction

    logic [XW-1:0] acc_x;
    logic [WW-1:0] w_rnd, w_trn;

    // Select and saturate the requested view
    always_comb begin
        acc_x = {acc[ACC_W-1], acc};
        w_rnd = sat_word(acc_x + RND_INC);
        w_trn = sat_word(acc_x);
        case (sel)
            EXT_HRND: res_o = {{OP_W{w_rnd[WW-1]}}, w_rnd[WW-1:OP_W]};
            EXT_HTRN: res_o = {{OP_W{w_trn[WW-1]}}, w_trn[WW-1:OP_W]};
            EXT_WORD: res_o = w_trn;
            default:  res_o = sat_word({acc, 1'b0});
        endcase
    end

    // R10: a word view that is unsaturated matches the low accumulator bits
    always_comb begin
        if (sel == EXT_WORD && res_o[WW-1] == acc[ACC_W-1])
            a_r10_word_pass: assert (res_o == acc[WW-1:0] || res_o == {1'b0, {(WW-1){1'b1}}}
                                     || res_o == {1'b1, {(WW-1){1'b0}}});
    end
endmodule

// File: rtl/frac_mac40.sv
// Top of the fractional MAC: multiplier, 40-bit accumulator, extractor.
// Accumulator updates one edge after en; res_o is combinational.
module frac_mac40
    import frac_mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int GUARD = 8,
    localparam int ACC_W = 2*OP_W + GUARD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        op,
    input  logic [2:0]        fmt,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    input  logic [1:0]        ext_sel,
    output logic [ACC_W-1:0]  acc_o,
    output logic [2*OP_W-1:0] res_o,
    output logic              ovf_o
);
    logic [ACC_W-1:0] prod;

    mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .a(a), .b(b), .fmt(mac_fmt_e'(fmt)), .prod_o(prod)
    );

    mac_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(en), .op(mac_op_e'(op)),
        .prod(prod), .acc_q(acc_o), .ovf_q(ovf_o)
    );

    mac_extract #(.OP_W(OP_W), .ACC_W(ACC_W)) u_ext (
        .acc(acc_o), .sel(mac_ext_e'(ext_sel)), .res_o(res_o)
    );
endmodule

// File: tb/sim_frac_mac40.sv
module sim_frac_mac40;
    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic [1:0] op = 2'd0, ext_sel = 2'd0;
    logic [2:0] fmt = 3'd0;
    logic [15:0] a = '0, b = '0;
    logic [39:0] acc_o;
    logic [31:0] res_o;
    logic ovf_o;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    frac_mac40 u0 (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .fmt(fmt), .a(a), .b(b),
                   .ext_sel(ext_sel), .acc_o(acc_o), .res_o(res_o), .ovf_o(ovf_o));

    // {op, fmt, a, b, expected acc}
    localparam int NV = 8;
    localparam logic [76:0] VEC [NV] = '{
        {2'd0, 3'd0, 16'h4000, 16'h4000, 40'h0020000000},  // R2 0.5*0.5
        {2'd1, 3'd0, 16'h8000, 16'h8000, 40'h009FFFFFFF},  // R2 -1*-1 clamp, R4 add
        {2'd2, 3'd1, 16'hFFFF, 16'hFFFF, 40'hFFA001FFFE},  // R3 UF, R4 sub
        {2'd0, 3'd2, 16'hFFFE, 16'h0003, 40'hFFFFFFFFFA},  // R3 SI
        {2'd0, 3'd3, 16'hFFFE, 16'h0003, 40'h000002FFFA},  // R3 UI
        {2'd0, 3'd4, 16'hFFFF, 16'hFFFF, 40'hFFFFFF0001},  // R3 mixed
        {2'd0, 3'd0, 16'h8000, 16'h4000, 40'hFFC0000000},  // R2 negative
        {2'd3, 3'd0, 16'h1234, 16'h5678, 40'h0000000000}   // R6 clear
    };

    task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] o, input logic [2:0] f, input logic [15:0] x,
                        input logic [15:0] y, input logic e);
        @(negedge clk);
        op = o; fmt = f; a = x; b = y; en = e;
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic ext(input string tag, input logic [1:0] s, input logic [31:0] exp);
        ext_sel = s;
        #1;
        chk(tag, {8'h0, res_o}, {8'h0, exp});
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset acc", acc_o, 40'h0);
        chk("R1 reset ovf", {39'h0, ovf_o}, 40'h0);
        ext("R8 reset round", 2'd0, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][76:75], VEC[i][74:72], VEC[i][71:56], VEC[i][55:40], 1'b1);
            chk($sformatf("R4 vector %0d acc", i), acc_o, VEC[i][39:0]);
            chk($sformatf("R7 vector %0d ovf", i), {39'h0, ovf_o}, 40'h0);
        end

        // Positive overflow after 129 unsigned-integer accumulations
        step(2'd0, 3'd3, 16'hFFFF, 16'hFFFF, 1'b1);
        for (int i = 0; i < 127; i++) step(2'd1, 3'd3, 16'hFFFF, 16'hFFFF, 1'b1);
        chk("R7 128 adds acc", acc_o, 40'h7FFF000080);
        chk("R7 128 adds no ovf", {39'h0, ovf_o}, 40'h0);
        step(2'd1, 3'd3, 16'hFFFF, 16'hFFFF, 1'b1);
        chk("R7 pos sat acc", acc_o, 40'h7FFFFFFFFF);
        chk("R7 pos ovf", {39'h0, ovf_o}, 40'h1);
        ext("R8 round pos sat", 2'd0, 32'h00007FFF);
        ext("R9 trunc pos sat", 2'd1, 32'h00007FFF);
        ext("R10 word pos sat", 2'd2, 32'h7FFFFFFF);
        ext("R11 x2 pos sat", 2'd3, 32'h7FFFFFFF);

        // Disabled clear is ignored
        step(2'd3, 3'd0, 16'h0, 16'h0, 1'b0);
        chk("R5 hold acc", acc_o, 40'h7FFFFFFFFF);
        chk("R5 hold ovf", {39'h0, ovf_o}, 40'h1);

        // Negative overflow
        step(2'd3, 3'd0, 16'h0, 16'h0, 1'b1);
        chk("R6 clear ovf", {39'h0, ovf_o}, 40'h0);
        for (int i = 0; i < 128; i++) step(2'd2, 3'd3, 16'hFFFF, 16'hFFFF, 1'b1);
        chk("R7 128 subs acc", acc_o, 40'h8000FFFF80);
        step(2'd2, 3'd3, 16'hFFFF, 16'hFFFF, 1'b1);
        chk("R7 neg sat acc", acc_o, 40'h8000000000);
        chk("R7 neg ovf", {39'h0, ovf_o}, 40'h1);
        ext("R8 round neg sat", 2'd0, 32'hFFFF8000);
        ext("R9 trunc neg sat", 2'd1, 32'hFFFF8000);
        ext("R10 word neg sat", 2'd2, 32'h80000000);
        ext("R11 x2 neg sat", 2'd3, 32'h80000000);

        // Rounding versus truncation
        step(2'd0, 3'd3, 16'h2469, 16'h8000, 1'b1);
        chk("R7 load clears ovf", {39'h0, ovf_o}, 40'h0);
        chk("R3 UI load", acc_o, 40'h0012348000);
        ext("R8 round up", 2'd0, 32'h00001235);
        ext("R9 trunc", 2'd1, 32'h00001234);
        ext("R10 word", 2'd2, 32'h12348000);
        ext("R11 doubled", 2'd3, 32'h24690000);

        // Rounding carries past the half-word range
        step(2'd0, 3'd3, 16'hFFFF, 16'h8000, 1'b1);
        ext("R8 round carry sat", 2'd0, 32'h00007FFF);
        ext("R9 trunc no carry", 2'd1, 32'h00007FFF);
        ext("R11 doubled sat", 2'd3, 32'h7FFFFFFF);

        // Negative half and exact doubled minimum
        step(2'd0, 3'd0, 16'h8000, 16'h4000, 1'b1);
        ext("R9 trunc negative", 2'd1, 32'hFFFFC000);
        ext("R11 doubled min", 2'd3, 32'h80000000);

        // Fraction corner extracted
        step(2'd0, 3'd0, 16'h8000, 16'h8000, 1'b1);
        chk("R2 corner acc", acc_o, 40'h007FFFFFFF);
        ext("R10 corner word", 2'd2, 32'h7FFFFFFF);
        ext("R8 corner round sat", 2'd0, 32'h00007FFF);

        // Reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset again", acc_o, 40'h0);
        rst_n = 1'b1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule